// File: doc/BRIEF.md
# ETU Time-Out Counter

This block measures card-side time-outs for a smart-card interface by counting elementary time units (ETUs). Software sets the limit by writing three byte-wide registers, which cannot be read back. A one-cycle ETU tick from the baud-rate logic advances the count. Counting happens only while a qualifier input reports that the card is active and its clock is running.

A mode input selects the layout. In joined mode the three bytes form one 24-bit limit, and only the main flag is used. In split mode the two lower bytes form a 16-bit limit for the main flag. The top byte forms an independent 8-bit limit for the auxiliary flag. Each flag rises once its counter has consumed the loaded number of qualified ticks. The flag stays high until that counter is loaded again.

Top module: `etu_timeout`

## Requirements
- R1: After a synchronous reset, all three limit bytes read as zero and both `tmo_main` and `tmo_aux` are low.
- R2: A write with `wr_en` high stores `wr_data` into the byte at address 0x09 (limit bits 7..0), 0x0A (bits 15..8) or 0x0B (bits 23..16). A write to any other address changes no byte, reloads no counter and leaves both flags and the counting unchanged.
- R3: In joined mode (`split_mode`=0) the limit is the 24-bit value {0x0B, 0x0A, 0x09}. `tmo_main` rises in the cycle after the qualified tick that consumes the last of that many ETUs.
- R4: In split mode (`split_mode`=1), the main counter counts the 16-bit value {0x0A, 0x09} and the auxiliary counter independently counts the 8-bit value at 0x0B. `tmo_aux` rises after that many qualified ticks.
- R5: A tick with `card_run` low is ignored by both counters.
- R6: An expiry flag, once high, stays high through any further ticks until its counter is reloaded.
- R7: A write to a limit byte reloads the counter that byte belongs to from the updated bytes and clears that counter's flag. In joined mode any of the three bytes reloads the main counter. In split mode 0x09 and 0x0A reload only the main counter, and 0x0B reloads only the auxiliary counter.
- R8: A loaded value of zero disables that counter, so its flag stays low whatever ticks arrive.
- R9: When a reload and a qualified tick fall in the same cycle, the reload wins and the tick is not applied to that counter.
- R10: A change of `split_mode` reloads both counters for the new layout and clears both flags. While in joined mode `tmo_aux` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| etu_tick | input | 1 | One-cycle pulse per elapsed ETU |
| card_run | input | 1 | High while the card is active with a running clock |
| split_mode | input | 1 | 0: one 24-bit counter, 1: 16-bit plus 8-bit counters |
| tmo_main | output | 1 | Sticky expiry flag of the 24-bit or 16-bit counter |
| tmo_aux | output | 1 | Sticky expiry flag of the 8-bit counter |

## Verification
Some properties are checked by assertions on every cycle:
- An expiry flag stays high until a reload (R6).
- A reload always clears the flag (R7).
- A counter holds its count and flag when no qualified tick arrives (R5).
- A flag is only ever high with its count at zero.
- At most one byte is written per cycle, and the auxiliary flag stays low in joined mode.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- The exact tick on which a flag rises for a given limit, including the full 24-bit span.
- Which counter each address reloads in each mode.
- Reload winning over a coincident tick, and zero acting as a disable.

// File: rtl/etu_to_pkg.sv
package etu_to_pkg;

    localparam int BYTE_W      = 8;
    localparam int N_BYTES     = 3;
    localparam int MAIN_BYTES  = 2;
    localparam int ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] BASE_ADDR = 8'h09;

    localparam int FULL_W = BYTE_W * N_BYTES;
    localparam int AUX_W  = BYTE_W * (N_BYTES - MAIN_BYTES);
    localparam int IDX_W  = $clog2(N_BYTES);

    typedef logic [N_BYTES-1:0][BYTE_W-1:0] cfg_t;

    typedef enum logic {
        MODE_JOINED = 1'b0,
        MODE_SPLIT  = 1'b1
    } tmo_mode_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic main;
        logic aux;
    } reload_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_t          sel;
        logic [ADDR_W-1:0] off;
        off     = addr - BASE_ADDR;
        sel.hit = (addr >= BASE_ADDR) && (off < ADDR_W'(N_BYTES));
        sel.idx = off[IDX_W-1:0];
        return sel;
    endfunction

    function automatic logic byte_is_aux(input int idx);
        return idx >= MAIN_BYTES;
    endfunction

endpackage

// File: rtl/etu_to_regfile.sv
module etu_to_regfile
    import etu_to_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg_next,
    output logic [N_BYTES-1:0] byte_wr
);

    reg_sel_t sel;
    cfg_t     cfg_q;

    assign sel = decode_addr(wr_addr);

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        assign byte_wr[i]  = wr_en && sel.hit && (sel.idx == IDX_W'(i));
        assign cfg_next[i] = byte_wr[i] ? wr_data : cfg_q[i];

        always_ff @(posedge clk) begin
            if (rst) cfg_q[i] <= '0;
            else     cfg_q[i] <= cfg_next[i];
        end

        assert_byte_lands_R2: assert property (@(posedge clk) disable iff (rst)
            byte_wr[i] |=> cfg_q[i] == $past(wr_data));
    end

    assert_single_byte_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(byte_wr));

endmodule

// File: rtl/etu_to_reload.sv
module etu_to_reload
    import etu_to_pkg::*;
(
    input  tmo_mode_e          mode,
    input  logic               mode_chg,
    input  logic [N_BYTES-1:0] byte_wr,
    input  cfg_t               cfg_next,
    output reload_t            reload,
    output logic [FULL_W-1:0]  main_val,
    output logic [AUX_W-1:0]   aux_val
);

    logic main_hit;
    logic aux_hit;

    always_comb begin
        main_hit = 1'b0;
        aux_hit  = 1'b0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (mode == MODE_SPLIT && byte_is_aux(i)) aux_hit  = aux_hit  | byte_wr[i];
            else                                      main_hit = main_hit | byte_wr[i];
        end
    end

    always_comb begin
        reload.main = mode_chg || main_hit;
        reload.aux  = mode_chg || aux_hit;
        if (mode == MODE_SPLIT) begin
            main_val = FULL_W'(cfg_next[MAIN_BYTES-1:0]);
            aux_val  = cfg_next[N_BYTES-1:MAIN_BYTES];
        end else begin
            main_val = cfg_next;
            aux_val  = '0;
        end
    end

endmodule

// File: rtl/etu_to_counter.sv
module etu_to_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            expired <= 1'b0;
        end else if (step && cnt != '0) begin
            cnt <= cnt - W'(1);
            if (cnt == W'(1)) expired <= 1'b1;
        end
    end

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        expired && !load |=> expired);

    assert_reload_clears_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load && !step |=> $stable(cnt) && $stable(expired));

    assert_flag_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        expired |-> cnt == '0);

    assert_zero_stays_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cnt == '0 && !load |=> expired == $past(expired));

endmodule

// File: rtl/etu_timeout.sv
module etu_timeout
    import etu_to_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       etu_tick,
    input  logic       card_run,
    input  logic       split_mode,
    output logic       tmo_main,
    output logic       tmo_aux
);

    tmo_mode_e          mode;
    tmo_mode_e          mode_q;
    logic               mode_chg;
    logic               step;
    cfg_t               cfg_next;
    logic [N_BYTES-1:0] byte_wr;
    reload_t            reload;
    logic [FULL_W-1:0]  main_val;
    logic [AUX_W-1:0]   aux_val;

    assign mode     = tmo_mode_e'(split_mode);
    assign mode_chg = (mode != mode_q);
    assign step     = etu_tick && card_run;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_JOINED;
        else     mode_q <= mode;
    end

    etu_to_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_next (cfg_next),
        .byte_wr  (byte_wr)
    );

    etu_to_reload u_reload (
        .mode     (mode),
        .mode_chg (mode_chg),
        .byte_wr  (byte_wr),
        .cfg_next (cfg_next),
        .reload   (reload),
        .main_val (main_val),
        .aux_val  (aux_val)
    );

    etu_to_counter #(.W(FULL_W)) u_main (
        .clk      (clk),
        .rst      (rst),
        .load     (reload.main),
        .load_val (main_val),
        .step     (step),
        .expired  (tmo_main)
    );

    etu_to_counter #(.W(AUX_W)) u_aux (
        .clk      (clk),
        .rst      (rst),
        .load     (reload.aux),
        .load_val (aux_val),
        .step     (step),
        .expired  (tmo_aux)
    );

    assert_aux_idle_joined_R10: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_JOINED |-> !tmo_aux);

    assert_mode_change_clears_R10: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !tmo_main && !tmo_aux);

endmodule

// File: tb/etu_timeout_test.sv
module etu_timeout_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       etu_tick = 1'b0;
    logic       card_run = 1'b0;
    logic       split_mode = 1'b0;
    logic       tmo_main;
    logic       tmo_aux;

    always #5 clk = ~clk;

    etu_timeout uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .etu_tick(etu_tick), .card_run(card_run), .split_mode(split_mode),
        .tmo_main(tmo_main), .tmo_aux(tmo_aux)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference model
    int  m_reg [3];
    int  m_cnt_main, m_cnt_aux;
    bit  m_flag_main, m_flag_aux, m_prev_split;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_reg[k]) m_reg[k] = 0;
            m_cnt_main = 0; m_cnt_aux = 0;
            m_flag_main = 0; m_flag_aux = 0; m_prev_split = 0;
        end else begin
            bit ld_main, ld_aux, chg, stp;
            int idx;
            idx = int'(wr_addr) - 9;
            chg = (split_mode != m_prev_split);
            m_prev_split = split_mode;
            ld_main = chg; ld_aux = chg;
            if (wr_en && idx >= 0 && idx <= 2) begin
                m_reg[idx] = int'(wr_data);
                if (split_mode && idx == 2) ld_aux = 1;
                else ld_main = 1;
            end
            stp = etu_tick && card_run;
            if (ld_main) begin
                m_cnt_main = split_mode ? m_reg[1] * 256 + m_reg[0]
                                        : m_reg[2] * 65536 + m_reg[1] * 256 + m_reg[0];
                m_flag_main = 0;
            end else if (stp && m_cnt_main != 0) begin
                m_cnt_main--;
                if (m_cnt_main == 0) m_flag_main = 1;
            end
            if (ld_aux) begin
                m_cnt_aux = split_mode ? m_reg[2] : 0;
                m_flag_aux = 0;
            end else if (stp && m_cnt_aux != 0) begin
                m_cnt_aux--;
                if (m_cnt_aux == 0) m_flag_aux = 1;
            end
        end
    end

    task automatic check(input bit act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(tmo_main, m_flag_main, cur_req, "model tmo_main");
            check(tmo_aux,  m_flag_aux,  cur_req, "model tmo_aux");
        end
        if (cycles > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit tk = 0);
        wr_en = 1; wr_addr = a; wr_data = d; etu_tick = tk;
        cyc();
        wr_en = 0; etu_tick = 0;
    endtask

    task automatic ticks(input int n);
        etu_tick = 1;
        cyc(n);
        etu_tick = 0;
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cyc();
        check(tmo_main, 0, "R1", "main after reset");
        check(tmo_aux,  0, "R1", "aux after reset");

        // joined mode, small limit
        cur_req = "R3"; card_run = 1;
        wr(8'h09, 8'd5);
        ticks(4);
        check(tmo_main, 0, "R3", "main before 5th tick");
        ticks(1);
        check(tmo_main, 1, "R3", "main on 5th tick");

        cur_req = "R6";
        ticks(7);
        check(tmo_main, 1, "R6", "main sticky after extra ticks");

        // card not running
        cur_req = "R5";
        wr(8'h09, 8'd3);
        check(tmo_main, 0, "R7", "main cleared by reload");
        card_run = 0;
        ticks(6);
        check(tmo_main, 0, "R5", "main ignores ticks without card");
        card_run = 1;
        ticks(3);
        check(tmo_main, 1, "R5", "main after qualified ticks");

        // stray addresses
        cur_req = "R2";
        wr(8'h09, 8'd2);
        wr(8'h0A, 8'd1);
        ticks(100);
        wr(8'h08, 8'hFF);
        wr(8'h0C, 8'h00);
        ticks(157);
        check(tmo_main, 0, "R2", "stray writes did not reload");
        ticks(1);
        check(tmo_main, 1, "R2", "main at 258 ticks");

        // full 24-bit span
        cur_req = "R3";
        wr(8'h09, 8'd1);
        wr(8'h0A, 8'd0);
        wr(8'h0B, 8'd1);
        ticks(65536);
        check(tmo_main, 0, "R3", "24-bit one tick short");
        ticks(1);
        check(tmo_main, 1, "R3", "24-bit limit reached");
        check(tmo_aux,  0, "R10", "aux low in joined mode");

        // split mode
        cur_req = "R4";
        split_mode = 1;
        cyc();
        check(tmo_main, 0, "R10", "mode change clears main");
        wr(8'h09, 8'd3);
        wr(8'h0B, 8'd2);
        ticks(2);
        check(tmo_aux,  1, "R4", "aux at 2 ticks");
        check(tmo_main, 0, "R4", "main still counting");
        ticks(1);
        check(tmo_main, 1, "R4", "main at 3 ticks");

        cur_req = "R7";
        wr(8'h0B, 8'd5);
        check(tmo_aux,  0, "R7", "aux cleared by its byte");
        check(tmo_main, 1, "R7", "main untouched by aux byte");

        cur_req = "R9";
        wr(8'h09, 8'd4, 1);
        ticks(3);
        check(tmo_main, 0, "R9", "reload beat coincident tick");
        check(tmo_aux,  0, "R9", "aux one tick left");
        ticks(1);
        check(tmo_main, 1, "R9", "main at 4 ticks");
        check(tmo_aux,  1, "R9", "aux at 5 ticks");

        // back to joined
        cur_req = "R10";
        split_mode = 0;
        cyc();
        check(tmo_main, 0, "R10", "main reloaded on mode change");
        check(tmo_aux,  0, "R10", "aux cleared on mode change");
        ticks(20);
        check(tmo_aux,  0, "R10", "aux quiet in joined mode");

        // zero disables
        cur_req = "R8";
        wr(8'h09, 8'd0);
        wr(8'h0A, 8'd0);
        wr(8'h0B, 8'd0, 1);
        ticks(30);
        check(tmo_main, 0, "R8", "zero limit never expires");
        split_mode = 1;
        cyc();
        ticks(30);
        check(tmo_main, 0, "R8", "zero main in split");
        check(tmo_aux,  0, "R8", "zero aux in split");

        cyc(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule